// File: doc/BRIEF.md
# Two-Stage Reset Sequencer

This block sequences reset release at power-up for a design that runs from a PLL. It works in two clock domains. In the free-running board clock domain, a fill-with-ones shift register holds the PLL in reset for a fixed number of board clock cycles and then lets it go. From then on the PLL reset stays released.

In the PLL output clock domain, the PLL lock flag and the board reset button are each brought in through a two-flop synchroniser. While the PLL is locked and the button is not pressed, a second shift register fills with ones. The system reset is released only when that register is full. A single sampled cycle of lost lock or a pressed button empties the register, which reasserts system reset. Release then waits for the full delay again.

Both outputs are active high and come up asserted from register initial values, so the block needs no reset of its own. Place it between the board clock and button pins on one side and the PLL and system logic on the other.

Top module: `rstseq_two_stage`

## Requirements
- R1: Both `pll_rst_o` and `sys_rst_o` are 1 at time zero, before any clock edge.
- R2: `pll_rst_o` stays 1 through the first `EXT_DELAY-1` rising edges of `ext_clk_i`, and is 0 after the `EXT_DELAY`-th edge (default 16).
- R3: Once `pll_rst_o` is 0 it stays 0, whatever `pll_locked_i` and `btn_rst_i` do.
- R4: A 0 sampled on `pll_locked_i` at a `pll_clk_i` edge makes `sys_rst_o` 1 no later than the third `pll_clk_i` edge, counting the sampling edge as the first. `sys_rst_o` stays 1 while lock is absent.
- R5: A 1 sampled on `btn_rst_i` (button pressed, active high) has the same effect as lost lock in R4. `sys_rst_o` stays 1 while the button is held.
- R6: When `pll_locked_i`=1 and `btn_rst_i`=0 are sampled on consecutive `pll_clk_i` edges, `sys_rst_o` falls on exactly the `(PLL_DELAY+2)`-th such edge. The 2 covers the synchroniser stages; the default `PLL_DELAY` is 16.
- R7: Any interruption of R6's condition, even for one cycle, restarts the full count. `sys_rst_o` is released again only after another `PLL_DELAY+2` uninterrupted qualifying edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ext_clk_i | input | 1 | Free-running board clock |
| pll_clk_i | input | 1 | PLL output clock |
| pll_locked_i | input | 1 | PLL lock flag, asynchronous to `pll_clk_i` |
| btn_rst_i | input | 1 | Board reset button, 1 = pressed, asynchronous |
| pll_rst_o | output | 1 | PLL reset, active high, `ext_clk_i` domain |
| sys_rst_o | output | 1 | System reset, active high, `pll_clk_i` domain |

## Verification
The bound checker verifies several properties on every edge of the relevant clock:
- `pll_rst_o` follows the board clock edge count exactly, and never rises again after release.
- A sampled loss of lock or a sampled button press shows up on `sys_rst_o` within three PLL edges.
- Every release of `sys_rst_o` is preceded by exactly `PLL_DELAY+2` uninterrupted qualifying input samples.

Some behaviour can only be shown through the bench's scenarios. These cover the time-zero state, holding reset through long stretches of absent lock or a held button, and the full restart after single-cycle glitches that land in the middle of a count. The behavioural model compares both outputs on every cycle of their own clocks.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

  // Default hold lengths, in cycles of the clock of each domain
  localparam int unsigned DEF_EXT_DELAY = 16;
  localparam int unsigned DEF_PLL_DELAY = 16;
  // Synchroniser depth for the asynchronous PLL-side inputs
  localparam int unsigned DEF_SYNC_STAGES = 2;

  // Bit positions inside the synchronised input vector
  localparam int unsigned IN_LOCK = 0;
  localparam int unsigned IN_BTN  = 1;
  localparam int unsigned IN_W    = 2;

endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] INIT = '0
) (
  input  logic             clk_i,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  // Flop chain; the first stage may go metastable, the last feeds logic
  logic [STAGES-1:0][WIDTH-1:0] chain_q = {STAGES{INIT}};

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i) begin
        chain_q[0] <= async_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk_i) begin
        chain_q <= {chain_q[STAGES-2:0], async_i};
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/rstseq_fill_chain.sv
module rstseq_fill_chain #(
  parameter int unsigned LEN = 16
) (
  input  logic clk_i,
  input  logic clear_i,   // synchronous, empties the chain
  output logic hold_o     // 1 until the last stage has filled
);

  // Ones enter at bit 0; the last stage turning to one ends the hold
  logic [LEN-1:0] fill_q = '0;

  generate
    if (LEN == 1) begin : g_one
      always_ff @(posedge clk_i) begin
        if (clear_i) fill_q <= 1'b0;
        else         fill_q <= 1'b1;
      end
    end else begin : g_many
      always_ff @(posedge clk_i) begin
        if (clear_i) fill_q <= '0;
        else         fill_q <= {fill_q[LEN-2:0], 1'b1};
      end
    end
  endgenerate

  assign hold_o = ~fill_q[LEN-1];

endmodule

// File: rtl/rstseq_two_stage.sv
module rstseq_two_stage
  import rstseq_pkg::*;
#(
  parameter int unsigned EXT_DELAY   = DEF_EXT_DELAY,
  parameter int unsigned PLL_DELAY   = DEF_PLL_DELAY,
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic ext_clk_i,
  input  logic pll_clk_i,
  input  logic pll_locked_i,
  input  logic btn_rst_i,
  output logic pll_rst_o,
  output logic sys_rst_o
);

  // Synchroniser start value: not locked, button pressed (safe side)
  localparam logic [IN_W-1:0] SYNC_INIT = IN_W'(1) << IN_BTN;

  // ---------------- board clock domain ----------------
  rstseq_fill_chain #(.LEN(EXT_DELAY)) ext_chain_i (
    .clk_i   (ext_clk_i),
    .clear_i (1'b0),
    .hold_o  (pll_rst_o)
  );

  // ---------------- PLL clock domain ----------------
  logic [IN_W-1:0] raw_in;
  logic [IN_W-1:0] syn_in;
  logic            run_ok;

  always_comb begin
    raw_in          = '0;
    raw_in[IN_LOCK] = pll_locked_i;
    raw_in[IN_BTN]  = btn_rst_i;
  end

  rstseq_sync #(
    .WIDTH  (IN_W),
    .STAGES (SYNC_STAGES),
    .INIT   (SYNC_INIT)
  ) in_sync_i (
    .clk_i   (pll_clk_i),
    .async_i (raw_in),
    .sync_o  (syn_in)
  );

  assign run_ok = syn_in[IN_LOCK] & ~syn_in[IN_BTN];

  rstseq_fill_chain #(.LEN(PLL_DELAY)) pll_chain_i (
    .clk_i   (pll_clk_i),
    .clear_i (~run_ok),
    .hold_o  (sys_rst_o)
  );

endmodule

// File: rtl/rstseq_two_stage_chk.sv
module rstseq_two_stage_chk #(
  parameter int unsigned EXT_DELAY   = 16,
  parameter int unsigned PLL_DELAY   = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input logic ext_clk_i,
  input logic pll_clk_i,
  input logic pll_locked_i,
  input logic btn_rst_i,
  input logic pll_rst_o,
  input logic sys_rst_o
);

  localparam int unsigned RUN_DONE = PLL_DELAY + SYNC_STAGES;
  localparam int unsigned EW = $clog2(EXT_DELAY + 2) + 1;
  localparam int unsigned RW = $clog2(RUN_DONE + 2) + 1;

  // Board-domain edge counter, saturating
  logic          ext_seen = 1'b0;
  logic [EW-1:0] ext_cnt  = '0;
  always_ff @(posedge ext_clk_i) begin
    ext_seen <= 1'b1;
    if (ext_cnt < EW'(EXT_DELAY)) ext_cnt <= ext_cnt + 1'b1;
  end

  // PLL-domain count of uninterrupted qualifying raw samples
  logic          pll_seen = 1'b0;
  logic [RW-1:0] run_cnt  = '0;
  always_ff @(posedge pll_clk_i) begin
    pll_seen <= 1'b1;
    if (!(pll_locked_i && !btn_rst_i)) run_cnt <= '0;
    else if (run_cnt < RW'(RUN_DONE + 1)) run_cnt <= run_cnt + 1'b1;
  end

  p_pll_rst_timing_r2: assert property (@(posedge ext_clk_i) disable iff (!ext_seen)
    pll_rst_o == (ext_cnt < EW'(EXT_DELAY)));

  p_pll_rst_sticky_r3: assert property (@(posedge ext_clk_i) disable iff (!ext_seen)
    !pll_rst_o |=> !pll_rst_o);

  p_lock_loss_reset_r4: assert property (@(posedge pll_clk_i) disable iff (!pll_seen)
    !pll_locked_i |-> ##3 sys_rst_o);

  p_button_reset_r5: assert property (@(posedge pll_clk_i) disable iff (!pll_seen)
    btn_rst_i |-> ##3 sys_rst_o);

  p_release_after_run_r6: assert property (@(posedge pll_clk_i) disable iff (!pll_seen)
    $fell(sys_rst_o) |-> run_cnt == RW'(RUN_DONE));

  p_no_release_early_r7: assert property (@(posedge pll_clk_i) disable iff (!pll_seen)
    (run_cnt < RW'(RUN_DONE - 1) && sys_rst_o) |=> sys_rst_o);

endmodule

bind rstseq_two_stage rstseq_two_stage_chk #(
  .EXT_DELAY   (EXT_DELAY),
  .PLL_DELAY   (PLL_DELAY),
  .SYNC_STAGES (SYNC_STAGES)
) chk_i (
  .ext_clk_i    (ext_clk_i),
  .pll_clk_i    (pll_clk_i),
  .pll_locked_i (pll_locked_i),
  .btn_rst_i    (btn_rst_i),
  .pll_rst_o    (pll_rst_o),
  .sys_rst_o    (sys_rst_o)
);

// File: tb/rstseq_two_stage_tb.sv
module rstseq_two_stage_tb_top;

  localparam int EXT_D = 16;
  localparam int PLL_D = 16;

  logic ext_clk = 1'b0;
  logic pll_clk = 1'b0;
  logic locked  = 1'b0;
  logic btn     = 1'b0;
  logic pll_rst;
  logic sys_rst;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #2 ext_clk = ~ext_clk;   // 250 MHz board clock
  always #3 pll_clk = ~pll_clk;   // PLL clock

  rstseq_two_stage #(.EXT_DELAY(EXT_D), .PLL_DELAY(PLL_D), .SYNC_STAGES(2)) dut_i (
    .ext_clk_i    (ext_clk),
    .pll_clk_i    (pll_clk),
    .pll_locked_i (locked),
    .btn_rst_i    (btn),
    .pll_rst_o    (pll_rst),
    .sys_rst_o    (sys_rst)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------- behavioural reference model ----------
  int ext_edges = 0;
  always @(posedge ext_clk) ext_edges++;
  always @(negedge ext_clk)
    if (!done) check(ext_edges <= EXT_D ? "R2 per-cycle" : "R3 per-cycle",
                     pll_rst, ext_edges < EXT_D);

  bit samples[$] = '{1'b0, 1'b0};  // raw qualifying samples in flight
  int good_run   = 0;
  always @(posedge pll_clk) begin
    bit s;
    s = samples.pop_front();
    good_run = s ? good_run + 1 : 0;
    samples.push_back(locked && !btn);
  end
  always @(negedge pll_clk)
    if (!done) check("R4/R5/R6/R7 per-cycle", sys_rst, good_run < PLL_D);

  task automatic wait_pll(input int n);
    repeat (n) @(negedge pll_clk);
  endtask

  // ---------- watchdog ----------
  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  // ---------- scenarios ----------
  initial begin
    #1;
    check("R1 pll_rst at time zero", pll_rst, 1'b1);
    check("R1 sys_rst at time zero", sys_rst, 1'b1);

    repeat (EXT_D - 1) @(negedge ext_clk);
    check("R2 pll_rst before last edge", pll_rst, 1'b1);
    @(negedge ext_clk);
    check("R2 pll_rst after last edge", pll_rst, 1'b0);

    // no lock
    wait_pll(20);
    check("R4 no lock holds sys_rst", sys_rst, 1'b1);

    // locked but button held
    locked = 1'b1; btn = 1'b1;
    wait_pll(20);
    check("R5 button held keeps sys_rst", sys_rst, 1'b1);

    // release: fall on edge PLL_D+2
    btn = 1'b0;
    wait_pll(PLL_D + 1);
    check("R6 one edge before release", sys_rst, 1'b1);
    wait_pll(1);
    check("R6 released", sys_rst, 1'b0);

    // one-cycle lock glitch
    wait_pll(5);
    locked = 1'b0;
    wait_pll(1);
    locked = 1'b1;
    wait_pll(2);
    check("R4 lock glitch reasserts", sys_rst, 1'b1);
    wait_pll(PLL_D - 1);
    check("R7 restart still holding", sys_rst, 1'b1);
    wait_pll(1);
    check("R7 released after restart", sys_rst, 1'b0);

    // one-cycle button press
    btn = 1'b1;
    wait_pll(1);
    btn = 1'b0;
    wait_pll(2);
    check("R5 button tap reasserts", sys_rst, 1'b1);

    // interrupt mid-count with a button tap
    wait_pll(8);
    check("R7 mid-count holding", sys_rst, 1'b1);
    btn = 1'b1;
    wait_pll(1);
    btn = 1'b0;
    wait_pll(PLL_D + 1);
    check("R7 mid-count restart holding", sys_rst, 1'b1);
    wait_pll(1);
    check("R7 mid-count restart released", sys_rst, 1'b0);

    check("R3 pll_rst unaffected by PLL side", pll_rst, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule